// File: doc/BRIEF.md
# 64-bit Rotate-Then-Clear-Right Execution Slice

This block decodes and executes one 32-bit instruction form. It rotates a 64-bit source value left by an amount taken from a second register value. It then keeps the upper part of the rotated value up to a selectable mask-end position and zeroes everything below that position. The decode, the barrel rotator, the mask generator and the optional condition-field update are all combinational. One register stage presents the results one cycle after the valid strobe.

A surrounding pipeline supplies the instruction word, the two operand values already read from its register file, and the current summary-overflow bit. It receives a write-back value, a destination index and a write enable. When the record flag is set, it also receives a 4-bit condition field. A word of any other format raises a no-match flag, and nothing is written for it.

Bit positions follow big-endian numbering. Instruction bit 0 is `instr[31]`, and data bit 0 is `res_out[63]`.

Top module: `rotclr_unit`

## Requirements
- R1: A word matches only when `instr[31:26]` equals 30 and `instr[4:1]` equals 9. The destination index is `instr[20:16]`, and `instr[0]` is the record flag.
- R2: The rotate amount is `rb_val[5:0]`. Bits 63..6 of `rb_val` have no effect on any output.
- R3: The mask-end value ME is `{instr[5], instr[10:6]}`, with `instr[5]` as its most significant bit. The result is `rs_val` rotated left by the amount, with only the top ME+1 bits kept (`res_out[63:63-ME]`) and all lower bits forced to zero.
- R4: When ME = 63 the rotated value passes unmasked. When ME = 0 only `res_out[63]` can be nonzero.
- R5: An amount of 0 yields `rs_val` with only the mask applied.
- R6: Outputs update one cycle after `in_valid`. In a cycle following no valid strobe, `wr_en`, `no_match`, `cr_we`, `res_out`, `dst_idx` and `cr_out` are all zero.
- R7: A non-matching valid word drives `no_match`=1 one cycle later, with `wr_en`=0, `cr_we`=0, `res_out`=0 and `dst_idx`=0. A matching valid word drives `wr_en`=1 and `no_match`=0.
- R8: When the record flag is 1 on a matching word, `cr_we` is 1 and `cr_out` = {LT, GT, EQ, SO} in bits 3..0. LT, GT and EQ come from a signed 64-bit comparison of the result with zero, and exactly one of them is set.
- R9: `cr_out[0]` equals `so_in` as sampled with the valid word. When the record flag is 0, `cr_we` is 0 and `cr_out` is 0.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Value to be rotated |
| rb_val | input | 64 | Register value whose low six bits give the rotate amount |
| so_in | input | 1 | Current summary-overflow bit |
| res_out | output | 64 | Registered result |
| dst_idx | output | 5 | Registered destination register index |
| wr_en | output | 1 | Result write enable |
| no_match | output | 1 | Valid word was not of this format |
| cr_we | output | 1 | Condition-field write enable |
| cr_out | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `in_valid`, `instr`, `rs_val`, `rb_val` and `so_in` are driven to known values from time zero. They also assume that `so_in` is presented in the same cycle as its instruction word. The stimulus drives every input at the falling edge from reset onward, so no input is ever unknown at a rising edge. It mixes random operands and random mask-end values with a random record flag. About one word in eight has a corrupted primary or extended opcode. Directed words cover the two mask extremes, a zero amount, amounts hidden behind upper `rb_val` bits, and results that are negative, positive and zero.

// File: rtl/rotclr_pkg.sv
package rotclr_pkg;

  localparam int XLEN = 64;
  localparam int SHW  = $clog2(XLEN);
  localparam int IW   = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] PRIMARY_OP = 6'd30;
  localparam logic [3:0] EXT_OP     = 4'd9;

  typedef struct packed {
    logic            match;
    logic            rec;
    logic [RIDX-1:0] ra;
    logic [SHW-1:0]  me;
  } rotclr_dec_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } rotclr_cr_t;

  // Signed compare against zero, summary overflow copied in.
  function automatic rotclr_cr_t cr_of(input logic [XLEN-1:0] v, input logic so);
    rotclr_cr_t c;
    c.lt = v[XLEN-1];
    c.eq = (v == '0);
    c.gt = !v[XLEN-1] && (v != '0);
    c.so = so;
    return c;
  endfunction

  // Reassemble the swapped mask-end field: bit 26 (instr[5]) is the MSB.
  function automatic logic [SHW-1:0] me_of(input logic [IW-1:0] w);
    return {w[5], w[10:6]};
  endfunction

endpackage

// File: rtl/rotclr_decode.sv
module rotclr_decode
  import rotclr_pkg::*;
(
  input  logic [IW-1:0] instr,
  output rotclr_dec_t   dec
);

  logic [5:0] prim_w;
  logic [3:0] ext_w;

  assign prim_w = instr[31:26];
  assign ext_w  = instr[4:1];

  always_comb begin
    dec.match = (prim_w == PRIMARY_OP) && (ext_w == EXT_OP);
    dec.rec   = instr[0];
    dec.ra    = instr[20:16];
    dec.me    = me_of(instr);
  end

endmodule

// File: rtl/rotclr_barrel.sv
module rotclr_barrel #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [0:SW];

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] rot_k;
    assign rot_k      = (stg[k] << S) | (stg[k] >> (W - S));
    assign stg[k + 1] = amt[k] ? rot_k : stg[k];
  end

  assign dout = stg[SW];

endmodule

// File: rtl/rotclr_mask.sv
module rotclr_mask #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [SW-1:0] me,
  output logic [W-1:0]  mask
);

  // Keep the top me+1 bits; a shift by W leaves zero, so me = W-1 gives all ones.
  function automatic logic [W-1:0] keep_top(input logic [SW-1:0] e);
    logic [W-1:0] ones;
    ones = '1;
    return ~(ones >> (int'(e) + 1));
  endfunction

  assign mask = keep_top(me);

endmodule

// File: rtl/rotclr_unit.sv
module rotclr_unit
  import rotclr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IW-1:0]   instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic            so_in,
  output logic [XLEN-1:0] res_out,
  output logic [RIDX-1:0] dst_idx,
  output logic            wr_en,
  output logic            no_match,
  output logic            cr_we,
  output logic [3:0]      cr_out
);

  rotclr_dec_t     dec;
  logic [SHW-1:0]  amt_w;
  logic [XLEN-1:0] rot_w;
  logic [XLEN-1:0] mask_w;
  logic [XLEN-1:0] res_w;
  logic            take_w;
  logic            bad_w;
  logic            rec_w;
  rotclr_cr_t      cr_w;

  rotclr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign amt_w = rb_val[SHW-1:0];

  rotclr_barrel #(.W(XLEN), .SW(SHW)) u_rot (
    .din  (rs_val),
    .amt  (amt_w),
    .dout (rot_w)
  );

  rotclr_mask #(.W(XLEN), .SW(SHW)) u_mask (
    .me   (dec.me),
    .mask (mask_w)
  );

  assign res_w  = rot_w & mask_w;
  assign take_w = in_valid && dec.match;
  assign bad_w  = in_valid && !dec.match;
  assign rec_w  = take_w && dec.rec;
  assign cr_w   = cr_of(res_w, so_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out  <= '0;
      dst_idx  <= '0;
      wr_en    <= 1'b0;
      no_match <= 1'b0;
      cr_we    <= 1'b0;
      cr_out   <= '0;
    end else begin
      res_out  <= take_w ? res_w : '0;
      dst_idx  <= take_w ? dec.ra : '0;
      wr_en    <= take_w;
      no_match <= bad_w;
      cr_we    <= rec_w;
      cr_out   <= rec_w ? cr_w : '0;
    end
  end

  AST_ROT_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_w == '0) |-> (rot_w == rs_val)); // R5
  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_w) == int'(dec.me) + 1); // R3
  AST_MASK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.me == '1) |-> (mask_w == '1)); // R4
  AST_RES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((res_out & ~$past(mask_w)) == '0)); // R3
  AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && no_match)); // R7
  AST_WE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || no_match) |-> $past(in_valid)); // R6
  AST_CR_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> wr_en); // R8
  AST_CR_ONE_REL: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_out[3:1]) == 1)); // R8
  AST_CR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (cr_out[3] == res_out[XLEN-1] && cr_out[1] == (res_out == '0))); // R8
  AST_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (cr_out[0] == $past(so_in))); // R9
  AST_CR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_we |-> (cr_out == '0)); // R9
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (res_out == '0 && dst_idx == '0 && !cr_we)); // R7

endmodule

// File: tb/tb_rotclr_unit.sv
module tb_rotclr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rb_val = '0;
  logic        so_in = 1'b0;
  logic [63:0] res_out;
  logic [4:0]  dst_idx;
  logic        wr_en, no_match, cr_we;
  logic [3:0]  cr_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rotclr_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs_val(rs_val), .rb_val(rb_val), .so_in(so_in), .res_out(res_out),
    .dst_idx(dst_idx), .wr_en(wr_en), .no_match(no_match), .cr_we(cr_we),
    .cr_out(cr_out)
  );

  function automatic logic [31:0] enc(input logic [4:0] rs, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic [5:0] me,
                                      input logic rc);
    return {6'd30, rs, ra, rb, me[4:0], me[5], 4'd9, rc};
  endfunction

  function automatic logic [63:0] ref_rot(input logic [63:0] v, input int n);
    logic [63:0] o;
    for (int i = 0; i < 64; i++) o[(i + n) % 64] = v[i];
    return o;
  endfunction

  function automatic logic [63:0] ref_res(input logic [63:0] v, input logic [63:0] b,
                                          input int me);
    logic [63:0] r;
    r = ref_rot(v, int'(b[5:0]));
    for (int j = 0; j < 64; j++) if (j > me) r[63 - j] = 1'b0;
    return r;
  endfunction

  function automatic logic [3:0] ref_cr(input logic [63:0] r, input logic so);
    if ($signed(r) < 0) return {3'b100, so};
    if (r == 0)         return {3'b001, so};
    return {3'b010, so};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(!wr_en && !no_match && !cr_we, tag, {61'd0, wr_en, no_match, cr_we}, 64'd0);
    chk(res_out == 0 && dst_idx == 0 && cr_out == 0, tag, res_out, 64'd0);
  endtask

  // Drive one word, sample after the capturing edge, then drop the strobe.
  task automatic run(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                     input logic so, input string tag);
    bit match;
    logic [5:0] me;
    logic [63:0] er;
    logic [3:0] ec;
    match = (w[31:26] == 6'd30) && (w[4:1] == 4'd9);
    me = {w[5], w[10:6]};
    er = match ? ref_res(a, b, int'(me)) : 64'd0;
    ec = (match && w[0]) ? ref_cr(er, so) : 4'd0;
    @(negedge clk);
    in_valid = 1'b1; instr = w; rs_val = a; rb_val = b; so_in = so;
    @(negedge clk);
    in_valid = 1'b0;
    chk(wr_en == match && no_match == !match, {tag, " R1 R7 enables"},
        {62'd0, wr_en, no_match}, {62'd0, match, !match});
    chk(res_out == er, {tag, " R3 result"}, res_out, er);
    chk(dst_idx == (match ? w[20:16] : 5'd0), {tag, " R1 dst"},
        {59'd0, dst_idx}, {59'd0, (match ? w[20:16] : 5'd0)});
    chk(cr_we == (match && w[0]) && cr_out == ec, {tag, " R8 R9 cr"},
        {59'd0, cr_we, cr_out}, {59'd0, (match && w[0]), ec});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check_idle("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R6 idle after reset");

    // R4: mask extremes
    run(enc(5'd1, 5'd7, 5'd2, 6'd63, 1'b0), 64'h0123_4567_89AB_CDEF, 64'd4, 1'b0, "R4 me63");
    run(enc(5'd1, 5'd8, 5'd2, 6'd0, 1'b1), 64'h8000_0000_0000_0001, 64'd0, 1'b0, "R4 me0");
    run(enc(5'd1, 5'd9, 5'd2, 6'd0, 1'b1), 64'h4000_0000_0000_0000, 64'd1, 1'b1, "R4 me0 rot");
    // R5: zero amount
    run(enc(5'd3, 5'd10, 5'd4, 6'd31, 1'b1), 64'hFFFF_0000_1234_5678, 64'd0, 1'b0, "R5 amt0");
    // R2: upper rb bits hidden
    run(enc(5'd3, 5'd11, 5'd4, 6'd47, 1'b0), 64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFC5, 1'b0, "R2 hiB");
    run(enc(5'd3, 5'd12, 5'd4, 6'd47, 1'b0), 64'hDEAD_BEEF_0000_0001, 64'h0000_0000_0000_0005, 1'b0, "R2 loB");
    // R3: split field with MSB only in instr[5]
    run(enc(5'd5, 5'd13, 5'd6, 6'd32, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, "R3 me32");
    // R8 sign cases
    run(enc(5'd5, 5'd14, 5'd6, 6'd63, 1'b1), 64'h0000_0000_0000_0000, 64'd9, 1'b1, "R8 zero");
    run(enc(5'd5, 5'd15, 5'd6, 6'd63, 1'b1), 64'h0000_0000_0000_0010, 64'd1, 1'b0, "R8 pos");
    run(enc(5'd5, 5'd16, 5'd6, 6'd63, 1'b1), 64'h0000_0000_0000_0001, 64'd63, 1'b1, "R8 neg");
    // R7: mismatches
    run(enc(5'd5, 5'd17, 5'd6, 6'd63, 1'b1) ^ 32'h0400_0000, 64'h1, 64'h1, 1'b1, "R7 prim");
    run(enc(5'd5, 5'd18, 5'd6, 6'd63, 1'b1) ^ 32'h0000_0004, 64'h1, 64'h1, 1'b1, "R7 ext");
    @(negedge clk);
    check_idle("R6 idle gap");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = enc(5'($urandom), 5'($urandom), 5'($urandom), 6'($urandom), 1'($urandom));
      if ($urandom % 8 == 0) begin
        if ($urandom % 2 == 0) w[31:26] = w[31:26] ^ 6'($urandom % 63 + 1);
        else w[4:1] = w[4:1] ^ 4'($urandom % 15 + 1);
      end
      run(w, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "rnd");
    end

    @(negedge clk);
    check_idle("R6 final idle");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule